// File: doc/BRIEF.md
# Coprocessor error interrupt controller

This block converts a floating-point error indication from the processor into an interrupt request. Error handling software then acknowledges the request by writing to a fixed I/O port. That write moves the block into an ignore-numeric-error state, which lets the processor continue past the faulting instruction. The ignore state holds only while the error indication stays active. Once the error clears, the block goes back to idle and is ready for the next error.

The feature is enabled by a single bit of a clock-divisor configuration word. The bit position is a parameter. While the bit is clear, the block produces no request and no ignore response. The error input is asynchronous to the block clock and passes through a synchroniser before any decision uses it. Reset is synchronous and active high.

Top module: `fpu_err_irq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `irq13_o` and `intr_o` are 0 and `ignne_n_o` is 1.
- R2: The enable is bit `MODE_BIT` (default 5) of `cfg_i`. While that bit is 0, `irq13_o` stays 0 and `ignne_n_o` stays 1 whatever `err_n_i` does. Clearing the bit while a request or ignore state is active returns the block to idle on the next clock edge.
- R3: With the enable set, a low level on `err_n_i` raises `irq13_o` to 1. `intr_o` carries the same level as `irq13_o`.
- R4: While `irq13_o` is 1, a write (`io_wr_i` = 1) to `io_addr_i` = `PORT_ADDR` (default 0x00F0) drives `irq13_o` to 0 and `ignne_n_o` to 0 on the next clock edge.
- R5: `ignne_n_o` stays 0 for as long as `err_n_i` stays low and the enable stays set.
- R6: `ignne_n_o` is 0 only while the synchronised error is active. It returns to 1 once the error input goes high.
- R7: When `err_n_i` goes high, the block returns to idle. A later low level on `err_n_i` raises `irq13_o` again.
- R8: A write to `PORT_ADDR` while no request is pending changes no output and leaves nothing pending. A write to any other address does not clear a pending request.
- R9: `err_n_i` passes through `SYNC_STAGES` (default 2) flip-flops. A change on it reaches the outputs on the third rising edge after it is applied, not the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| err_n_i | input | 1 | Asynchronous active-low floating-point error from the processor |
| cfg_i | input | CFG_W (8) | Clock-divisor configuration word; bit MODE_BIT enables the feature |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_addr_i | input | ADDR_W (16) | I/O address qualifying `io_wr_i` |
| irq13_o | output | 1 | Internal IRQ13 request level |
| intr_o | output | 1 | Interrupt output towards the processor |
| ignne_n_o | output | 1 | Active-low ignore-numeric-error output |

## Verification
The assertions assume three things. `cfg_i` is a configuration register value that is stable against the block clock. The I/O write strobe and address are synchronous to `clk`. Any decision follows the synchronised error level, not the raw pin. The stimulus changes every input only at the falling clock edge. It moves `err_n_i` only between full, settled levels, so the synchroniser never meets a half-clock pulse. The port write is applied only as a single-cycle strobe while the error is held.

// File: rtl/fpu_err_irq_pkg.sv
package fpu_err_irq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_IGN  = 2'd2
   } fei_state_e;
endpackage

// File: rtl/fpu_err_sync.sv
module fpu_err_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fpu_err_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RESET_VAL}};
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fpu_err_port_dec.sv
module fpu_err_port_dec #(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h00F0
) (
   input  logic              io_wr_i,
   input  logic [ADDR_W-1:0] io_addr_i,
   output logic              hit_o
);
   always_comb hit_o = io_wr_i && (io_addr_i == PORT_ADDR);
endmodule

// File: rtl/fpu_err_fsm.sv
module fpu_err_fsm
   import fpu_err_irq_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic mode_i,
   input  logic err_i,
   input  logic clr_i,
   output logic req_o,
   output logic ign_o
);
   fei_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!mode_i || !err_i) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: st_d = ST_REQ;
            ST_REQ:  if (clr_i) st_d = ST_IGN;
            ST_IGN:  st_d = ST_IGN;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   assign req_o = (st_q == ST_REQ);
   assign ign_o = (st_q == ST_IGN);
endmodule

// File: rtl/fpu_err_irq.sv
module fpu_err_irq #(
   parameter int                CFG_W       = 8,
   parameter int                MODE_BIT    = 5,
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR   = 'h00F0,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              err_n_i,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic              io_wr_i,
   input  logic [ADDR_W-1:0] io_addr_i,
   output logic              irq13_o,
   output logic              intr_o,
   output logic              ignne_n_o
);
   if (MODE_BIT < 0 || MODE_BIT >= CFG_W) begin : g_bad_mode
      $error("fpu_err_irq: MODE_BIT outside cfg_i");
   end

   logic err_n_s;
   logic err_act;
   logic mode_on;
   logic wr_hit;
   logic req;
   logic ign;

   fpu_err_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (err_n_i),
      .q_o (err_n_s)
   );

   fpu_err_port_dec #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
      .io_wr_i   (io_wr_i),
      .io_addr_i (io_addr_i),
      .hit_o     (wr_hit)
   );

   assign err_act = ~err_n_s;
   assign mode_on = cfg_i[MODE_BIT];

   fpu_err_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .mode_i (mode_on),
      .err_i  (err_act),
      .clr_i  (wr_hit),
      .req_o  (req),
      .ign_o  (ign)
   );

   assign irq13_o   = req;
   assign intr_o    = req;
   assign ignne_n_o = ~ign;
endmodule

// File: rtl/fpu_err_irq_chk.sv
module fpu_err_irq_chk (
   input logic clk,
   input logic rst,
   input logic mode,
   input logic err_s,
   input logic wr_hit,
   input logic irq13,
   input logic intr,
   input logic ignne_n
);
   p_reset_idle_r1: assert property (@(posedge clk)
      (!rst && $past(rst)) |-> (!irq13 && !intr && ignne_n));

   p_mode_gate_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(mode) |-> (!irq13 && ignne_n));

   p_raise_from_err_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(irq13) |-> ($past(err_s) && $past(mode)));

   p_clear_on_write_r4: assert property (@(posedge clk) disable iff (rst)
      (irq13 && wr_hit && err_s && mode) |=> (!irq13 && !ignne_n));

   p_hold_ign_r5: assert property (@(posedge clk) disable iff (rst)
      (!ignne_n && err_s && mode) |=> !ignne_n);

   p_ign_needs_err_r6: assert property (@(posedge clk) disable iff (rst)
      !ignne_n |-> $past(err_s));

   p_release_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !err_s |=> (!irq13 && ignne_n));

   p_keep_req_r8: assert property (@(posedge clk) disable iff (rst)
      (irq13 && !wr_hit && err_s && mode) |=> irq13);

   p_excl_out_r3: assert property (@(posedge clk) disable iff (rst)
      !(irq13 && !ignne_n));
endmodule

bind fpu_err_irq fpu_err_irq_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .mode    (mode_on),
   .err_s   (err_act),
   .wr_hit  (wr_hit),
   .irq13   (irq13_o),
   .intr    (intr_o),
   .ignne_n (ignne_n_o)
);

// File: tb/fpu_err_irq_tb_top.sv
module fpu_err_irq_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        err_n = 1'b1;
   logic [7:0]  cfg = 8'h00;
   logic        io_wr = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic        irq13, intr, ignne_n;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fpu_err_irq dut_i (
      .clk       (clk),
      .rst       (rst),
      .err_n_i   (err_n),
      .cfg_i     (cfg),
      .io_wr_i   (io_wr),
      .io_addr_i (io_addr),
      .irq13_o   (irq13),
      .intr_o    (intr),
      .ignne_n_o (ignne_n)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_out(input string tag, input logic e_irq, input logic e_ign_n);
      checks++;
      if (irq13 !== e_irq || intr !== e_irq || ignne_n !== e_ign_n) begin
         failures++;
         $display("FAIL %s: irq13=%b intr=%b ignne_n=%b expected irq13=%b intr=%b ignne_n=%b",
                  tag, irq13, intr, ignne_n, e_irq, e_irq, e_ign_n);
      end
   endtask

   task automatic io_write(input logic [15:0] a);
      io_addr = a;
      io_wr   = 1'b1;
      step(1);
      io_wr   = 1'b0;
      io_addr = 16'h0000;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      err_n = 1'b0;
      cfg = 8'h20;
      step(3);
      check_out("R1 during reset", 1'b0, 1'b1);
      err_n = 1'b1;
      step(3);
      rst = 1'b0;
      step(1);
      check_out("R1 after reset", 1'b0, 1'b1);
   endtask

   task automatic t_mode_off();
      cfg = 8'hDF;
      err_n = 1'b0;
      step(5);
      check_out("R2 mode clear, error low", 1'b0, 1'b1);
      io_write(16'h00F0);
      step(2);
      check_out("R2 mode clear, port write", 1'b0, 1'b1);
      err_n = 1'b1;
      step(4);
      cfg = 8'h20;
   endtask

   task automatic t_raise_latency();
      err_n = 1'b0;
      step(2);
      check_out("R9 two edges after error", 1'b0, 1'b1);
      step(1);
      check_out("R3 request raised", 1'b1, 1'b1);
   endtask

   task automatic t_wrong_addr();
      io_write(16'h00F1);
      check_out("R8 other address keeps request", 1'b1, 1'b1);
      io_addr = 16'h00F0;
      step(1);
      io_addr = 16'h0000;
      check_out("R8 address without strobe keeps request", 1'b1, 1'b1);
   endtask

   task automatic t_clear();
      io_write(16'h00F0);
      check_out("R4 write clears request, asserts ignore", 1'b0, 1'b0);
   endtask

   task automatic t_hold();
      step(20);
      check_out("R5 ignore held while error low", 1'b0, 1'b0);
      io_write(16'h00F0);
      check_out("R5 repeat write keeps ignore", 1'b0, 1'b0);
   endtask

   task automatic t_release();
      err_n = 1'b1;
      step(2);
      check_out("R9 ignore still low two edges after release", 1'b0, 1'b0);
      step(1);
      check_out("R6 ignore released with error", 1'b0, 1'b1);
      err_n = 1'b0;
      step(3);
      check_out("R7 new error raises request again", 1'b1, 1'b1);
      err_n = 1'b1;
      step(3);
      check_out("R7 request drops with error", 1'b0, 1'b1);
   endtask

   task automatic t_write_idle();
      io_write(16'h00F0);
      step(1);
      check_out("R8 idle write no effect", 1'b0, 1'b1);
      err_n = 1'b0;
      step(3);
      check_out("R8 request after idle write", 1'b1, 1'b1);
   endtask

   task automatic t_mode_drop();
      cfg = 8'h00;
      step(1);
      check_out("R2 mode drop clears request", 1'b0, 1'b1);
      cfg = 8'h20;
      step(1);
      check_out("R3 mode back raises request", 1'b1, 1'b1);
      io_write(16'h00F0);
      check_out("R4 clear after mode return", 1'b0, 1'b0);
      cfg = 8'h00;
      step(1);
      check_out("R2 mode drop releases ignore", 1'b0, 1'b1);
      err_n = 1'b1;
      cfg = 8'h20;
      step(4);
      check_out("R7 idle after all", 1'b0, 1'b1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_mode_off();
      t_raise_latency();
      t_wrong_addr();
      t_clear();
      t_hold();
      t_release();
      t_write_idle();
      t_mode_drop();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule